// File: doc/BRIEF.md
# Mode-Pin Monitor and Lock Sequencer

This block supervises the conditions under which a frequency synthesizer's output clock may be trusted. It watches three mode-select pins and a reference-activity pulse, and decides when the loop must drop its lock and acquire it again. Any relock trigger restarts a lock-time down-counter, and the clock-valid flag stays low until that counter has run out with no new trigger.

The mode pins are asynchronous. Each one passes through a two-flop synchronizer and a debounce filter before its edges are used. A change on pin 0 or pin 1 always forces a relock. A change on pin 2 forces a relock only under some values of a 3-bit configuration input. If no reference-activity pulse arrives for a set number of system clocks, the reference is treated as broken, and a relock is held until pulses come back.

A part strapped as field-programmed needs an initialization step before first use. Pins 0 and 1 together must show a minimum number of filtered toggles before the part counts as initialized, and until then the output is never declared valid. A factory-programmed part skips this step.

Top module: `modepin_lock_seq`

## Requirements
- R1: A filtered change on mode pin 0 or mode pin 1 raises `relock_req_o` for one cycle, DEB_CYC+2 clock edges after the pin change is set up. `lock_valid_o` falls at that same edge.
- R2: A filtered change on mode pin 2 causes a relock only when `pin2_cfg_i` is 3, 4, 5 or 6. Under the other four values the change has no effect: `relock_req_o` stays low and `lock_valid_o` stays high.
- R3: A pin level that holds for fewer than DEB_CYC consecutive synchronized samples is treated as a glitch. It causes no relock and no toggle count.
- R4: If REF_TIMEOUT clocks pass with no pulse on `ref_edge_i`, `relock_req_o` goes high and stays high, and `lock_valid_o` stays low, until pulses come back.
- R5: Every relock trigger reloads the lock timer with LOCK_CYC. `lock_valid_o` becomes high exactly LOCK_CYC edges after the last trigger edge, provided the part is initialized. After reset, the timer starts loaded.
- R6: With `field_prog_i` high, `init_done_o` stays low until INIT_TOGGLES filtered toggles have been seen on pins 0 and 1 combined. Toggles on pin 2 do not count. The toggle count saturates. `lock_valid_o` is never high while `init_done_o` is low.
- R7: With `field_prog_i` low, `init_done_o` is high from reset onward.
- R8: While reset is held, `relock_req_o` and `lock_valid_o` are low. All mode pins are taken as low at reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. Assert and release it synchronously to `clk`. |
| mode_pin_i | input | 3 | Asynchronous mode-select pins. Bit 0 and bit 1 always relock; bit 2 relocks depending on the configuration. |
| pin2_cfg_i | input | 3 | Configuration value that decides whether pin 2 changes relock (3 to 6 do) |
| field_prog_i | input | 1 | Strap input, static: 1 means field-programmed and the toggle initialization is required |
| ref_edge_i | input | 1 | One-cycle pulse from the reference-activity detector, synchronous to `clk` |
| relock_req_o | output | 1 | Request to the loop to drop lock and acquire it again |
| lock_valid_o | output | 1 | The output clock is valid |
| init_done_o | output | 1 | The power-up initialization has been satisfied |

## Verification
A pin change driven just before edge E0 reaches the debounced level at E(DEB_CYC+1). It shows as a relock request and a dropped valid flag after E(DEB_CYC+2), and valid returns after E(DEB_CYC+2+LOCK_CYC). The initialized flag rises after the same edge as the relock request. The bench drives the pins at a falling edge and samples at later falling edges. It checks each result on both sides of its due edge, so both a late output and an early output are caught. The sweep covers all eight configuration values for pin 2. Reference starvation is checked with margins that allow for the phase of the activity pulses.

// File: rtl/mpl_pkg.sv
package mpl_pkg;

  localparam int NPINS = 3;

  typedef logic [2:0] pin2_cfg_t;

  // Configuration values under which a pin-2 change disturbs the loop.
  function automatic logic pin2_relocks(input pin2_cfg_t cfg);
    return (cfg == 3'd3) || (cfg == 3'd4) || (cfg == 3'd5) || (cfg == 3'd6);
  endfunction

endpackage

// File: rtl/mpl_pin_filter.sv
module mpl_pin_filter #(
  parameter int DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic toggle_o
);
  localparam int DW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

  logic         meta_q, sync_q, filt_q;
  logic [DW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b0;
      sync_q   <= 1'b0;
      filt_q   <= 1'b0;
      run_q    <= '0;
      toggle_o <= 1'b0;
    end else begin
      meta_q   <= pin_i;
      sync_q   <= meta_q;
      toggle_o <= 1'b0;
      if (sync_q == filt_q) begin
        run_q <= '0;
      end else if (run_q == DW'(DEB_CYC - 1)) begin
        filt_q   <= sync_q;
        run_q    <= '0;
        toggle_o <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // A debounced level only moves to a value the synchronizer has held.
  generate
    if (DEB_CYC >= 2) begin : g_chk
      assert_debounce_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |-> ($past(sync_q) == filt_q) && ($past(sync_q, 2) == filt_q));
    end
  endgenerate

endmodule

// File: rtl/mpl_ref_watch.sv
module mpl_ref_watch #(
  parameter int REF_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge_i,
  output logic ref_lost_o
);
  localparam int TW = $clog2(REF_TIMEOUT + 1);

  logic [TW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           idle_q <= '0;
    else if (ref_edge_i)                  idle_q <= '0;
    else if (idle_q != TW'(REF_TIMEOUT))  idle_q <= idle_q + 1'b1;
  end

  assign ref_lost_o = (idle_q == TW'(REF_TIMEOUT));

  assert_edge_clears_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge_i |=> !ref_lost_o);

endmodule

// File: rtl/mpl_init_gate.sv
module mpl_init_gate #(
  parameter int INIT_TOGGLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic field_prog_i,
  input  logic step_i,
  output logic done_o
);
  localparam int IW = $clog2(INIT_TOGGLES + 1);

  logic [IW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   seen_q <= '0;
    else if (step_i && seen_q != IW'(INIT_TOGGLES)) seen_q <= seen_q + 1'b1;
  end

  assign done_o = !field_prog_i || (seen_q == IW'(INIT_TOGGLES));

  assert_count_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q >= $past(seen_q));

endmodule

// File: rtl/mpl_lock_timer.sv
module mpl_lock_timer #(
  parameter int LOCK_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic init_ok_i,
  output logic relock_o,
  output logic valid_o
);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= LW'(LOCK_CYC);
      relock_o <= 1'b0;
    end else begin
      relock_o <= trig_i;
      if (trig_i)             left_q <= LW'(LOCK_CYC);
      else if (left_q != '0)  left_q <= left_q - 1'b1;
    end
  end

  assign valid_o = init_ok_i && (left_q == '0);

  assert_trigger_drops_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> !valid_o);

endmodule

// File: rtl/modepin_lock_seq.sv
module modepin_lock_seq
  import mpl_pkg::*;
#(
  parameter int DEB_CYC      = 4,
  parameter int REF_TIMEOUT  = 64,
  parameter int LOCK_CYC     = 1000,
  parameter int INIT_TOGGLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_pin_i,
  input  logic [2:0] pin2_cfg_i,
  input  logic       field_prog_i,
  input  logic       ref_edge_i,
  output logic       relock_req_o,
  output logic       lock_valid_o,
  output logic       init_done_o
);

  logic [NPINS-1:0] tog;
  logic             ref_lost;
  logic             pin2_hit;
  logic             trig;

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      mpl_pin_filter #(.DEB_CYC(DEB_CYC)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (mode_pin_i[p]),
        .toggle_o (tog[p])
      );
    end
  endgenerate

  mpl_ref_watch #(.REF_TIMEOUT(REF_TIMEOUT)) u_ref (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_edge_i (ref_edge_i),
    .ref_lost_o (ref_lost)
  );

  mpl_init_gate #(.INIT_TOGGLES(INIT_TOGGLES)) u_init (
    .clk          (clk),
    .rst_n        (rst_n),
    .field_prog_i (field_prog_i),
    .step_i       (tog[0] | tog[1]),
    .done_o       (init_done_o)
  );

  assign pin2_hit = tog[2] && pin2_relocks(pin2_cfg_i);
  assign trig     = tog[0] | tog[1] | pin2_hit | ref_lost;

  mpl_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig),
    .init_ok_i (init_done_o),
    .relock_o  (relock_req_o),
    .valid_o   (lock_valid_o)
  );

  assert_valid_needs_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_valid_o |-> init_done_o);

  assert_valid_falls_on_relock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_valid_o) |-> relock_req_o);

  assert_pin2_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tog[2] && !pin2_relocks(pin2_cfg_i) && !tog[0] && !tog[1] && !ref_lost) |=> !relock_req_o);

endmodule

// File: tb/sim_modepin_lock_seq.sv
`timescale 1ns/1ps
module sim_modepin_lock_seq;
  localparam int D = 3;
  localparam int T = 16;
  localparam int L = 20;
  localparam int I = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_pin = 3'b000;
  logic [2:0] cfg = 3'd0;
  logic       field_prog = 1'b0;
  logic       ref_edge = 1'b0;
  logic       ref_run = 1'b1;
  logic       relock, valid, init_done;
  int         n_chk = 0, n_bad = 0, cyc = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  modepin_lock_seq #(.DEB_CYC(D), .REF_TIMEOUT(T), .LOCK_CYC(L), .INIT_TOGGLES(I)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_pin_i(mode_pin), .pin2_cfg_i(cfg),
    .field_prog_i(field_prog), .ref_edge_i(ref_edge),
    .relock_req_o(relock), .lock_valid_o(valid), .init_done_o(init_done));

  initial forever begin
    @(negedge clk);
    cyc++;
    ref_edge = ref_run && (cyc % 4 == 0);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic fp);
    field_prog = fp;
    mode_pin = 3'b000;
    rst_n = 1'b0;
    step(3);
    check("R8 relock low in reset", relock, 1'b0);
    check("R8 valid low in reset", valid, 1'b0);
    rst_n = 1'b1;
  endtask

  // Flip a pin at the current falling edge, then check both sides of each due edge.
  task automatic pin_relock(input int idx, input logic expect_relock, input string tag);
    mode_pin[idx] = ~mode_pin[idx];
    step(D + 2);
    check({tag, " relock not early"}, relock, 1'b0);
    step(1);
    check({tag, " relock due"}, relock, expect_relock);
    check({tag, " valid after change"}, valid, !expect_relock);
    step(1);
    check({tag, " relock one cycle"}, relock, 1'b0);
    if (expect_relock) begin
      step(L - 2);
      check("R5 valid still low", valid, 1'b0);
      step(1);
      check("R5 valid after lock time", valid, 1'b1);
    end
    step(4);
  endtask

  initial begin
    // Factory-programmed part
    do_reset(1'b0);
    check("R7 init high from reset", init_done, 1'b1);
    step(L - 1);
    check("R5 valid low before lock time", valid, 1'b0);
    step(1);
    check("R5 valid after lock time from reset", valid, 1'b1);
    step(4);

    pin_relock(0, 1'b1, "R1 pin0");
    pin_relock(1, 1'b1, "R1 pin1");
    pin_relock(0, 1'b1, "R1 pin0 back");

    for (int c = 0; c < 8; c++) begin
      cfg = 3'(c);
      pin_relock(2, (c >= 3 && c <= 6), $sformatf("R2 pin2 cfg%0d", c));
    end

    // R3: two-cycle glitch on pin 0 is filtered
    mode_pin[0] = ~mode_pin[0];
    step(2);
    mode_pin[0] = ~mode_pin[0];
    for (int k = 0; k < 10; k++) begin
      step(1);
      if (relock) check("R3 glitch relock", relock, 1'b0);
    end
    check("R3 glitch keeps valid", valid, 1'b1);

    // R4: reference starvation
    ref_run = 1'b0;
    step(12);
    check("R4 no loss before timeout", relock, 1'b0);
    step(18);
    check("R4 relock held while lost", relock, 1'b1);
    check("R4 valid low while lost", valid, 1'b0);
    step(10);
    check("R4 relock still held", relock, 1'b1);
    ref_run = 1'b1;
    step(L + 8);
    check("R4 relock released", relock, 1'b0);
    check("R4 valid restored", valid, 1'b1);

    // Field-programmed part
    do_reset(1'b1);
    check("R6 init low from reset", init_done, 1'b0);
    step(L + 5);
    check("R6 valid low before init", valid, 1'b0);
    mode_pin[2] = 1'b1;
    step(12);
    check("R6 pin2 toggle not counted", init_done, 1'b0);
    mode_pin[0] = 1'b1;
    step(12);
    check("R6 one toggle not enough", init_done, 1'b0);
    mode_pin[1] = 1'b1;
    step(L + 5);
    check("R6 two toggles not enough", init_done, 1'b0);
    check("R6 valid low with two toggles", valid, 1'b0);
    mode_pin[0] = 1'b0;
    step(D + 2);
    check("R6 init not early", init_done, 1'b0);
    step(1);
    check("R6 init after third toggle", init_done, 1'b1);
    step(L - 1);
    check("R6 valid still low", valid, 1'b0);
    step(1);
    check("R6 valid after init and lock", valid, 1'b1);
    mode_pin[1] = 1'b0;
    step(L + 8);
    check("R6 init saturated", init_done, 1'b1);
    check("R6 valid after further toggle", valid, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule